// File: doc/BRIEF.md
# PCI Power-State Request Handshake

This block is the register unit that links a PCI host's power-state field to an internal CPU. When the host writes a supported target state, the block does four things in one clock edge. It records the new state and drops a CPU-owned ready flag. It posts a request bit for that state and logs an event that can raise an interrupt to the CPU.

The CPU handles the request in three steps. It reads a status register, which returns the logged events and clears them. It reads the control register to find which state the host asked for. When it has prepared, it writes 1 to the ready bit. The host can poll the ready bit, but it never has to wait for it. Power or clock may vanish at any moment after the host write, so the block keeps no sequence in progress that must run to completion.

All CPU-side registers are 4 bits wide and share one bit layout. Bit 0 is the ready bit in the control register. Bits 1, 2 and 3 stand for D0, D1 and D3hot in the control, status and mask registers alike.

Top module: `pwr_req_hshk`

## Requirements
- R1: After reset, host_pstate is 00 (D0) and host_rdy is 1. The control register (offset 0) reads 4'b0001, the status register (offset 1) reads 0, the mask register (offset 2) reads 4'b1110, and cpu_irq is 0.
- R2: A host write of a supported code (00 = D0, 01 = D1, 11 = D3hot) is visible on host_pstate after the next clock edge. host_pstate holds the last accepted code.
- R3: An accepted host write clears the ready bit (control bit 0 and host_rdy) on the same edge.
- R4: An accepted host write leaves exactly one request bit set in control bits 3:1: bit 1 for D0, bit 2 for D1, bit 3 for D3hot. Any earlier request bit is removed.
- R5: A host write of code 10 (D2) is ignored. host_pstate, the control register, host_rdy, the status register and cpu_irq all stay unchanged.
- R6: An accepted host write sets the status bit for the target state (status bits 3:1, same layout as the request bits), whether or not that state is masked. Status bits of earlier requests that have not been read accumulate.
- R7: A CPU read of the status register returns its current value, and the register is cleared after that edge. If an accepted host write falls in the same cycle as the read, the new event's status bit stays set.
- R8: cpu_irq is 1 exactly when some status bit is set whose mask bit (mask register bits 3:1, writable by the CPU) is 0. Mask bit 0 reads 0.
- R9: A CPU write to the control register with bit 0 set sets the ready bit. A write with bit 0 clear leaves it unchanged. A host write accepted in the same cycle takes precedence and leaves the ready bit at 0.
- R10: CPU writes to the control register never change the request bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_en | input | 1 | Host write strobe for the power-state field |
| host_wdata | input | 2 | Power-state code written by the host |
| host_pstate | output | 2 | Last accepted power-state code, host read-back |
| host_rdy | output | 1 | Ready bit as seen by the host |
| cpu_addr | input | CPU_AW (4) | CPU register offset: 0 control, 1 status, 2 mask |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_rd_en | input | 1 | CPU read strobe; a read of offset 1 clears the status register |
| cpu_wdata | input | 4 | CPU write data |
| cpu_rdata | output | 4 | CPU read data for cpu_addr, combinational |
| cpu_irq | output | 1 | Interrupt to the CPU |

## Verification
Host writes go to each supported code in turn, and then to the D2 code. This separates the accepted path (state, request bit, ready cleared) from the ignored path. Successive requests are issued with and without a status read in between, which tells replacement of request bits apart from accumulation of status bits. The mask is stepped through all-masked, all-open and partly-open settings to show that interrupt gating follows the individual states. Same-cycle collisions show which side wins: a host write against a status read, and a host write against a ready write.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;

  typedef enum logic [1:0] {
    PS_D0  = 2'b00,
    PS_D1  = 2'b01,
    PS_D2  = 2'b10,
    PS_D3H = 2'b11
  } pstate_e;

  // number of states that can be requested (D0, D1, D3hot)
  localparam int unsigned NUM_REQ     = 3;
  // ready bit position in the control register
  localparam int unsigned CTL_RDY_BIT = 0;
  // lowest bit of the per-state fields (request, status, mask)
  localparam int unsigned SLOT_LSB    = 1;
  // CPU register width derived from the layout
  localparam int unsigned REG_W       = SLOT_LSB + NUM_REQ;

  // power-state code served by each request slot
  function automatic logic [1:0] slot_code(input int unsigned slot);
    case (slot)
      0:       slot_code = PS_D0;
      1:       slot_code = PS_D1;
      default: slot_code = PS_D3H;
    endcase
  endfunction

endpackage

// File: rtl/pwr_host_if.sv
module pwr_host_if
  import pwr_req_pkg::*;
#(
  parameter int unsigned NREQ = NUM_REQ
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr_en,
  input  logic [1:0]      host_wdata,
  output logic            accept,
  output logic [NREQ-1:0] tgt_onehot,
  output logic [1:0]      pstate
);

  logic [NREQ-1:0] hit;

  // one comparator per supported state; D2 matches no slot
  for (genvar g = 0; g < NREQ; g++) begin : g_slot
    assign hit[g] = (host_wdata == slot_code(g));
  end

  assign accept     = host_wr_en && (|hit);
  assign tgt_onehot = hit;

  pstate_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (accept) st_d = pstate_e'(host_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= PS_D0;
    else if (accept) st_q <= st_d;
  end

  assign pstate = st_q;

endmodule

// File: rtl/pwr_req_flags.sv
module pwr_req_flags #(
  parameter int unsigned NREQ = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [NREQ-1:0] tgt_onehot,
  input  logic            rdy_set,
  output logic [NREQ-1:0] req_q,
  output logic            rdy_q
);

  logic [NREQ-1:0] req_d;
  logic            rdy_d;
  logic            upd;

  // host request has priority over the CPU ready write
  always_comb begin
    req_d = req_q;
    rdy_d = rdy_q;
    if (accept) begin
      req_d = tgt_onehot;
      rdy_d = 1'b0;
    end else if (rdy_set) begin
      rdy_d = 1'b1;
    end
  end

  assign upd = accept || rdy_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      rdy_q <= 1'b1;
    end else if (upd) begin
      req_q <= req_d;
      rdy_q <= rdy_d;
    end
  end

endmodule

// File: rtl/pwr_irq_ctl.sv
module pwr_irq_ctl #(
  parameter int unsigned NREQ = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [NREQ-1:0] tgt_onehot,
  input  logic            stat_rd,
  input  logic            mask_we,
  input  logic [NREQ-1:0] mask_wdata,
  output logic [NREQ-1:0] stat_q,
  output logic [NREQ-1:0] mask_q,
  output logic            irq
);

  logic [NREQ-1:0] stat_d;
  logic            stat_en;

  // read clears, a simultaneous new event survives the clear
  always_comb begin
    stat_d = stat_q;
    if (stat_rd) stat_d = '0;
    if (accept)  stat_d = stat_d | tgt_onehot;
  end

  assign stat_en = accept || stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign irq = |(stat_q & ~mask_q);

endmodule

// File: rtl/pwr_req_hshk.sv
module pwr_req_hshk
  import pwr_req_pkg::*;
#(
  parameter int unsigned CPU_AW   = 4,
  parameter int unsigned OFS_CTL  = 0,
  parameter int unsigned OFS_STAT = 1,
  parameter int unsigned OFS_MASK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [1:0]        host_wdata,
  output logic [1:0]        host_pstate,
  output logic              host_rdy,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr_en,
  input  logic              cpu_rd_en,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  output logic              cpu_irq
);

  localparam int unsigned NREQ = NUM_REQ;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // CPU register decode
  logic sel_ctl, sel_stat, sel_mask;
  logic rdy_set, stat_rd, mask_we;

  assign sel_ctl  = (cpu_addr == CPU_AW'(OFS_CTL));
  assign sel_stat = (cpu_addr == CPU_AW'(OFS_STAT));
  assign sel_mask = (cpu_addr == CPU_AW'(OFS_MASK));

  assign rdy_set  = cpu_wr_en && sel_ctl && cpu_wdata[CTL_RDY_BIT];
  assign stat_rd  = cpu_rd_en && sel_stat;
  assign mask_we  = cpu_wr_en && sel_mask;

  logic            accept;
  logic [NREQ-1:0] tgt_onehot;
  logic [NREQ-1:0] req_q;
  logic            rdy_q;
  logic [NREQ-1:0] stat_q;
  logic [NREQ-1:0] mask_q;

  pwr_host_if #(.NREQ(NREQ)) u_host (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_wr_en (host_wr_en),
    .host_wdata (host_wdata),
    .accept     (accept),
    .tgt_onehot (tgt_onehot),
    .pstate     (host_pstate)
  );

  pwr_req_flags #(.NREQ(NREQ)) u_flags (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (accept),
    .tgt_onehot (tgt_onehot),
    .rdy_set    (rdy_set),
    .req_q      (req_q),
    .rdy_q      (rdy_q)
  );

  pwr_irq_ctl #(.NREQ(NREQ)) u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (accept),
    .tgt_onehot (tgt_onehot),
    .stat_rd    (stat_rd),
    .mask_we    (mask_we),
    .mask_wdata (cpu_wdata[SLOT_LSB +: NREQ]),
    .stat_q     (stat_q),
    .mask_q     (mask_q),
    .irq        (cpu_irq)
  );

  assign host_rdy = rdy_q;

  // read mux; all per-state fields share one bit layout
  always_comb begin
    cpu_rdata = '0;
    if (sel_ctl) begin
      cpu_rdata[CTL_RDY_BIT]       = rdy_q;
      cpu_rdata[SLOT_LSB +: NREQ]  = req_q;
    end else if (sel_stat) begin
      cpu_rdata[SLOT_LSB +: NREQ]  = stat_q;
    end else if (sel_mask) begin
      cpu_rdata[SLOT_LSB +: NREQ]  = mask_q;
    end
  end

endmodule

// File: rtl/pwr_req_chk.sv
module pwr_req_chk #(
  parameter int unsigned NREQ = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_wr_en,
  input logic [1:0]      host_wdata,
  input logic [1:0]      host_pstate,
  input logic            host_rdy,
  input logic            cpu_irq,
  input logic            accept,
  input logic            stat_rd,
  input logic            rdy_set,
  input logic [NREQ-1:0] req_q,
  input logic [NREQ-1:0] stat_q
);

  assert_pstate_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> host_pstate == $past(host_wdata));

  assert_ready_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !host_rdy);

  assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_q));

  assert_req_posted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> $countones(req_q) == 1);

  assert_d2_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wdata == 2'b10) |=> ($stable(host_pstate) && $stable(req_q)));

  assert_event_logged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> stat_q != '0);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !accept) |=> !cpu_irq);

  assert_ready_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_set && !accept) |=> host_rdy);

endmodule

bind pwr_req_hshk pwr_req_chk #(.NREQ(NREQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .host_wr_en  (host_wr_en),
  .host_wdata  (host_wdata),
  .host_pstate (host_pstate),
  .host_rdy    (host_rdy),
  .cpu_irq     (cpu_irq),
  .accept      (accept),
  .stat_rd     (stat_rd),
  .rdy_set     (rdy_set),
  .req_q       (req_q),
  .stat_q      (stat_q)
);

// File: tb/tb_pwr_req_hshk.sv
module tb_pwr_req_hshk;
  import pwr_req_pkg::*;

  logic             clk;
  logic             rst_n;
  logic             host_wr_en;
  logic [1:0]       host_wdata;
  logic [1:0]       host_pstate;
  logic             host_rdy;
  logic [3:0]       cpu_addr;
  logic             cpu_wr_en;
  logic             cpu_rd_en;
  logic [REG_W-1:0] cpu_wdata;
  logic [REG_W-1:0] cpu_rdata;
  logic             cpu_irq;

  int checks = 0;
  int errors = 0;

  localparam logic [3:0] A_CTL = 4'd0, A_STAT = 4'd1, A_MASK = 4'd2;

  pwr_req_hshk dut (
    .clk (clk), .rst_n (rst_n),
    .host_wr_en (host_wr_en), .host_wdata (host_wdata),
    .host_pstate (host_pstate), .host_rdy (host_rdy),
    .cpu_addr (cpu_addr), .cpu_wr_en (cpu_wr_en), .cpu_rd_en (cpu_rd_en),
    .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata), .cpu_irq (cpu_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, capture read data before the edge,
  // return just after the edge so registered effects are visible
  task automatic step(input logic hwe, input logic [1:0] hd, input logic cwe,
                      input logic cre, input logic [3:0] ca, input logic [3:0] cd,
                      output logic [3:0] rd);
    @(negedge clk);
    host_wr_en = hwe; host_wdata = hd;
    cpu_wr_en = cwe; cpu_rd_en = cre; cpu_addr = ca; cpu_wdata = cd;
    #1 rd = cpu_rdata;
    @(posedge clk);
    #1;
    host_wr_en = 1'b0; cpu_wr_en = 1'b0; cpu_rd_en = 1'b0;
  endtask

  task automatic hw(input logic [1:0] code);
    logic [3:0] rd;
    step(1'b1, code, 1'b0, 1'b0, A_CTL, 4'h0, rd);
  endtask

  task automatic cw(input logic [3:0] a, input logic [3:0] d);
    logic [3:0] rd;
    step(1'b0, 2'b00, 1'b1, 1'b0, a, d, rd);
  endtask

  task automatic cr(input logic [3:0] a, input string req, input int exp);
    logic [3:0] rd;
    step(1'b0, 2'b00, 1'b0, 1'b1, a, 4'h0, rd);
    chk(req, rd, exp);
  endtask

  task automatic t_reset;
    chk("R1 pstate", host_pstate, 0);
    chk("R1 host_rdy", host_rdy, 1);
    chk("R1 irq", cpu_irq, 0);
    cr(A_CTL, "R1 ctl", 4'b0001);
    cr(A_MASK, "R1 mask", 4'b1110);
    cr(A_STAT, "R1 status", 4'b0000);
  endtask

  task automatic t_masked_request;
    hw(2'b01);
    chk("R2 pstate D1", host_pstate, 1);
    chk("R3 host_rdy cleared", host_rdy, 0);
    chk("R8 irq masked", cpu_irq, 0);
    cr(A_CTL, "R4 ctl D1", 4'b0100);
    cr(A_STAT, "R6 status masked", 4'b0100);
    cr(A_STAT, "R7 status cleared", 4'b0000);
  endtask

  task automatic t_open_request;
    cw(A_MASK, 4'b0000);
    hw(2'b11);
    chk("R2 pstate D3", host_pstate, 3);
    chk("R8 irq open", cpu_irq, 1);
    cr(A_CTL, "R4 ctl D3", 4'b1000);
    cr(A_STAT, "R7 status read", 4'b1000);
    chk("R7 irq after read", cpu_irq, 0);
  endtask

  task automatic t_partial_mask;
    cw(A_MASK, 4'b1000);
    hw(2'b11);
    chk("R8 irq D3 masked", cpu_irq, 0);
    hw(2'b01);
    chk("R8 irq D1 open", cpu_irq, 1);
    cr(A_CTL, "R4 replace", 4'b0100);
    cr(A_STAT, "R6 accumulate", 4'b1100);
    chk("R7 irq cleared", cpu_irq, 0);
    hw(2'b00);
    chk("R2 pstate D0", host_pstate, 0);
    cr(A_CTL, "R4 ctl D0", 4'b0010);
    cw(A_MASK, 4'b1110);
    cr(A_STAT, "R6 D0 logged", 4'b0010);
  endtask

  task automatic t_ready_write;
    cw(A_CTL, 4'b1110);
    chk("R9 zero keeps ready low", host_rdy, 0);
    cr(A_CTL, "R10 reqs untouched", 4'b0010);
    cw(A_CTL, 4'b0001);
    chk("R9 ready set", host_rdy, 1);
    cr(A_CTL, "R10 ctl after ready", 4'b0011);
  endtask

  task automatic t_d2_ignored;
    cw(A_MASK, 4'b0000);
    hw(2'b10);
    chk("R5 pstate", host_pstate, 0);
    chk("R5 host_rdy", host_rdy, 1);
    chk("R5 irq", cpu_irq, 0);
    cr(A_CTL, "R5 ctl", 4'b0011);
    cr(A_STAT, "R5 status", 4'b0000);
  endtask

  task automatic t_collisions;
    logic [3:0] rd;
    hw(2'b00);
    chk("R8 irq pending", cpu_irq, 1);
    step(1'b1, 2'b01, 1'b0, 1'b1, A_STAT, 4'h0, rd);
    chk("R7 read value in collision", rd, 4'b0010);
    chk("R7 irq survives collision", cpu_irq, 1);
    cr(A_STAT, "R7 new event kept", 4'b0100);
    cw(A_CTL, 4'b0001);
    chk("R9 ready before collision", host_rdy, 1);
    step(1'b1, 2'b11, 1'b1, 1'b0, A_CTL, 4'b0001, rd);
    chk("R9 host wins collision", host_rdy, 0);
    cr(A_CTL, "R4 ctl after collision", 4'b1000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_wr_en = 1'b0; host_wdata = 2'b00;
    cpu_wr_en = 1'b0; cpu_rd_en = 1'b0; cpu_addr = 4'd0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_masked_request();
    t_open_request();
    t_partial_mask();
    t_ready_write();
    t_d2_ignored();
    t_collisions();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule